// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Write Target

This block is the target side of a 4-bit multiplexed firmware bus, handling write cycles only. It watches an active-low frame strobe and a 4-bit bus and waits for a start code. When one arrives, it checks an ID select nibble against its strap ID. It then shifts in a multi-nibble address and a size nibble, and builds a data byte from two nibbles. After the data it takes the bus for the turnaround, drives a sync acknowledge, and releases the bus again.

A matching write of size one byte gives one write strobe, `wr_valid`. In that same clock `wr_addr` and `wr_data` carry the full address and byte. The strobe is a plain valid with no ready. The bus protocol has fixed timing and cannot stall, so no back-pressure exists: the consumer must take the write in the clock the strobe is high. `wr_addr` and `wr_data` may change in any other clock.

Every write cycle is 17 clocks long, counted from the clock that holds the start nibble. A frame strobe that goes low in the middle of a cycle ends that cycle, and start detection begins again from that nibble.

Top module: `fwb_write_target`

## Requirements
- R1: A cycle begins only on a clock where `frame_n` is low and `bus_in` carries the start code 4'b1110. Any other nibble sampled with `frame_n` low starts nothing.
- R2: While `frame_n` stays low, each sampled nibble replaces the previous decision. The ID select is taken on the first clock with `frame_n` high, and only if the last nibble sampled with `frame_n` low was 4'b1110.
- R3: The target takes part only when the ID select nibble equals `strap_id`. If it does not match, there is no strobe and `bus_oe` stays low.
- R4: The seven nibbles after the ID form the 28-bit address, most-significant nibble first.
- R5: The nibble after the address is the size. Only 4'b0000 (one byte) is accepted. Any other value drops the cycle with no strobe and no bus drive.
- R6: The data byte arrives as two nibbles, with the low nibble (bits 3:0) first and the high nibble (bits 7:4) second.
- R7: `wr_valid` is high for exactly one clock, in the clock that follows the rising edge sampling the high data nibble. `wr_addr` and `wr_data` are valid in that clock.
- R8: In clock 13 the host owns the bus and `bus_oe` is low. In clock 14 `bus_oe` is high and `bus_out` is 4'b1111 (not the sync value).
- R9: In clock 15 the target drives the sync value 4'b0000 with `bus_oe` high.
- R10: In clock 16 the target drives 4'b1111. From clock 17 `bus_oe` is low, and the target is idle and ready for a new start.
- R11: A low `frame_n` on any clock of a cycle under way aborts it, so no later strobe or drive from that cycle appears. That nibble is itself checked as a possible start.
- R12: During and after reset, `bus_oe` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe |
| bus_in | input | 4 | Nibble currently on the bus |
| bus_out | output | 4 | Nibble driven by the target when `bus_oe` is high |
| bus_oe | output | 1 | Target drive enable for the bus |
| strap_id | input | 4 | Strap ID compared against the ID select nibble |
| wr_valid | output | 1 | One-clock write strobe |
| wr_addr | output | 28 | Write address, valid with `wr_valid` |
| wr_data | output | 8 | Write data byte, valid with `wr_valid` |

## Verification
Clock k is the clock whose rising edge samples field k, so the start is clock 1 and the high data nibble is clock 12. All outputs come from registered state. The strobe is due one edge after the high data nibble is sampled, and the target drive follows at the next three edges.

The bench drives each field on a falling edge and, on that same falling edge, samples the outputs that the previous rising edge produced. This places the strobe at field 13, the turnaround at 14, sync at 15, the released 1111 at 16 and the release at 17. Each accepted write pushes its expected address and byte into a queue. A monitor pops the queue whenever the strobe appears, so any strobe that arrives early, late, twice or unexpectedly is reported.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] START_CODE = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_ONE   = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_CODE  = 4'b0000;
  localparam logic [NIB_W-1:0] IDLE_CODE  = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ADDR,
    ST_SIZE,
    ST_DATA,
    ST_HTAR,
    ST_TTAR,
    ST_SYNC,
    ST_REL
  } fwb_state_e;
endpackage

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_in,
  input  logic [NIB_W-1:0] strap_id,
  output fwb_state_e       state,
  output logic             addr_en,
  output logic             data_en
);
  localparam int MAXN  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  fwb_state_e       nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    if (!frame_n) begin
      nxt     = (bus_in == START_CODE) ? ST_ARMED : ST_IDLE;
      cnt_nxt = '0;
    end else begin
      unique case (state)
        ST_IDLE:  nxt = ST_IDLE;
        ST_ARMED: begin
          nxt     = (bus_in == strap_id) ? ST_ADDR : ST_IDLE;
          cnt_nxt = '0;
        end
        ST_ADDR: begin
          if (cnt == ADDR_LAST) begin
            nxt     = ST_SIZE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_SIZE: begin
          nxt     = (bus_in == SIZE_ONE) ? ST_DATA : ST_IDLE;
          cnt_nxt = '0;
        end
        ST_DATA: begin
          if (cnt == DATA_LAST) begin
            nxt     = ST_HTAR;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
        ST_HTAR: nxt = ST_TTAR;
        ST_TTAR: nxt = ST_SYNC;
        ST_SYNC: nxt = ST_REL;
        ST_REL:  nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign addr_en = frame_n && (state == ST_ADDR);
  assign data_en = frame_n && (state == ST_DATA);

  // R3
  id_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && frame_n && bus_in != strap_id) |=> state == ST_IDLE);

  // R5
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SIZE && frame_n && bus_in != SIZE_ONE) |=> state == ST_IDLE);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && state != ST_IDLE && bus_in != START_CODE) |=> state == ST_IDLE);
endmodule

// File: rtl/fwb_capture.sv
module fwb_capture
  import fwb_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       addr_en,
  input  logic                       data_en,
  input  logic [NIB_W-1:0]           bus_in,
  output logic [NIB_W*ADDR_NIBS-1:0] addr,
  output logic [NIB_W*DATA_NIBS-1:0] data
);
  localparam int ADDR_W = NIB_W * ADDR_NIBS;
  localparam int DATA_W = NIB_W * DATA_NIBS;

  // Address: most-significant nibble first, shift toward the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= {addr[ADDR_W-NIB_W-1:0], bus_in};
  end

  // Data: least-significant nibble first, shift toward the bottom.
  generate
    if (DATA_NIBS > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data <= '0;
        else if (data_en) data <= {bus_in, data[DATA_W-1:NIB_W]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data <= '0;
        else if (data_en) data <= bus_in;
      end
    end
  endgenerate
endmodule

// File: rtl/fwb_drive.sv
module fwb_drive
  import fwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  fwb_state_e       state,
  output logic             wr_valid,
  output logic             bus_oe,
  output logic [NIB_W-1:0] bus_out
);
  always_comb begin
    wr_valid = (state == ST_HTAR);
    bus_oe   = (state == ST_TTAR) || (state == ST_SYNC) || (state == ST_REL);
    bus_out  = (state == ST_SYNC) ? SYNC_CODE : IDLE_CODE;
  end

  // R7
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R8
  host_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !bus_oe);

  // R8
  take_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && frame_n) |=> (bus_oe && bus_out == IDLE_CODE));

  // R9
  sync_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_oe) && frame_n) |=> (bus_oe && bus_out == SYNC_CODE));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_out == SYNC_CODE && frame_n) |=> (bus_oe && bus_out == IDLE_CODE) ##1 !bus_oe);
endmodule

// File: rtl/fwb_write_target.sv
module fwb_write_target
  import fwb_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_n,
  input  logic [3:0]             bus_in,
  output logic [3:0]             bus_out,
  output logic                   bus_oe,
  input  logic [3:0]             strap_id,
  output logic                   wr_valid,
  output logic [4*ADDR_NIBS-1:0] wr_addr,
  output logic [4*DATA_NIBS-1:0] wr_data
);
  fwb_state_e state;
  logic       addr_en, data_en;

  fwb_seq #(.ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .bus_in   (bus_in),
    .strap_id (strap_id),
    .state    (state),
    .addr_en  (addr_en),
    .data_en  (data_en)
  );

  fwb_capture #(.ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_en (addr_en),
    .data_en (data_en),
    .bus_in  (bus_in),
    .addr    (wr_addr),
    .data    (wr_data)
  );

  fwb_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .state    (state),
    .wr_valid (wr_valid),
    .bus_oe   (bus_oe),
    .bus_out  (bus_out)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bus_oe && !wr_valid));
endmodule

// File: tb/test_fwb_write_target.sv
module test_fwb_write_target;
  localparam logic [3:0] STRAP = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        wr_valid;
  logic [27:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [35:0] exp_q[$];

  always #4 clk = ~clk;

  fwb_write_target i_fwb_write_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(STRAP),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    bus_in  = n;
  endtask

  // Scoreboard monitor: each strobe pops one expected write.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", {wr_addr, wr_data}, '0);
      end else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} === e, "R4/R6 write contents", {wr_addr, wr_data}, e);
      end
    end
  end

  function automatic logic [3:0] field(input int k, input logic [3:0] id,
                                       input logic [27:0] a, input logic [3:0] sz,
                                       input logic [7:0] d);
    if (k == 2) return id;
    if (k >= 3 && k <= 9) return a[4*(9-k) +: 4];
    if (k == 10) return sz;
    if (k == 11) return d[3:0];
    if (k == 12) return d[7:4];
    return 4'hF;
  endfunction

  task automatic lead_in(input int pre);
    case (pre)
      0: drv(1'b0, 4'hE);
      1: begin drv(1'b0, 4'hE); drv(1'b0, 4'hE); drv(1'b0, 4'hE); end
      2: begin drv(1'b0, 4'hE); drv(1'b0, 4'h3); drv(1'b0, 4'hE); end
      3: begin drv(1'b0, 4'hE); drv(1'b0, 4'h3); end
      default: drv(1'b0, 4'h5);
    endcase
  endtask

  // Full cycle, outputs checked at every field position 2..18.
  task automatic write_cycle(input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz,
                             input logic [7:0] d, input int pre, input string tag);
    bit ok;
    ok = (pre <= 2) && (id == STRAP) && (sz == 4'h0);
    if (ok) exp_q.push_back({a, d});
    lead_in(pre);
    for (int k = 2; k <= 18; k++) begin
      bit eo;
      bit ew;
      @(negedge clk);
      ew = ok && (k == 13);
      eo = ok && (k >= 14) && (k <= 16);
      check(wr_valid === ew, $sformatf("R7 %s strobe at field %0d", tag, k), {35'd0, wr_valid}, {35'd0, ew});
      check(bus_oe === eo, $sformatf("%s %s drive enable at field %0d",
            (k <= 14) ? "R8" : ((k == 15) ? "R9" : "R10"), tag, k), {35'd0, bus_oe}, {35'd0, eo});
      if (eo) begin
        logic [3:0] en;
        en = (k == 15) ? 4'h0 : 4'hF;
        check(bus_out === en, $sformatf("%s %s drive value at field %0d",
              (k == 15) ? "R9" : ((k == 14) ? "R8" : "R10"), tag, k), {32'd0, bus_out}, {32'd0, en});
      end
      frame_n = 1'b1;
      bus_in  = field(k, id, a, 4'h0 | sz, d);
    end
  endtask

  // Partial cycle up to field n, to be aborted by the next start.
  task automatic partial(input logic [27:0] a, input logic [7:0] d, input int n);
    if (n >= 12) exp_q.push_back({a, d});
    drv(1'b0, 4'hE);
    for (int k = 2; k <= n; k++) drv(1'b1, field(k, STRAP, a, 4'h0, d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_oe === 1'b0 && wr_valid === 1'b0, "R12 reset outputs", {34'd0, bus_oe, wr_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_oe === 1'b0 && wr_valid === 1'b0, "R12 after reset", {34'd0, bus_oe, wr_valid}, '0);

    write_cycle(STRAP, 28'h1234567, 4'h0, 8'hA5, 0, "R4 R6 basic");
    write_cycle(STRAP, 28'hFEDCBA9, 4'h0, 8'h3C, 1, "R2 repeated starts");
    write_cycle(STRAP, 28'h0000001, 4'h0, 8'h81, 2, "R2 last start wins");
    write_cycle(STRAP, 28'h0ABCDEF, 4'h0, 8'h11, 3, "R2 cancelled start");
    write_cycle(STRAP, 28'h0ABCDEF, 4'h0, 8'h22, 4, "R1 non-start nibble");
    write_cycle(4'h6,  28'h7654321, 4'h0, 8'h33, 0, "R3 id mismatch");
    write_cycle(STRAP, 28'h7654321, 4'h1, 8'h44, 0, "R5 size one rejected");
    write_cycle(STRAP, 28'h7654321, 4'hF, 8'h45, 0, "R5 size F rejected");
    partial(28'h1111111, 8'h55, 5);
    write_cycle(STRAP, 28'h2222222, 4'h0, 8'h66, 0, "R11 abort in address");
    partial(28'h3333333, 8'h77, 14);
    write_cycle(STRAP, 28'h4444444, 4'h0, 8'h88, 0, "R11 abort in turnaround");
    write_cycle(STRAP, 28'hFFFFFFF, 4'h0, 8'h00, 0, "R4 R6 all ones address");
    write_cycle(STRAP, 28'h8000000, 4'h0, 8'hFF, 0, "R10 back to idle");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 missing strobes", 36'(exp_q.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule